// File: doc/BRIEF.md
# Dithered Half-Period PWM Generator

This block produces one pulse-width-modulated output from an 11-bit period word and an 11-bit duty word. A timebase counter advances on each clock cycle in which the count-enable tick is high. The output level comes from comparing that counter with a compare value, and the alignment select picks left-aligned, right-aligned (inverted) or center-aligned (up/down counting) operation. A fourth select code turns the channel off.

With dither enabled, the counter runs over half the programmed period twice per PWM period. The upper ten bits of the duty word set the compare value in both halves. If the duty word's lowest bit is set, the second half compares against one count more. This gives the output half-count duty resolution and, in left alignment, four edges per period. New period, duty, dither and alignment values are held in shadow registers. While the channel runs, they take effect only at the start of a full PWM period.

Top module: `pwm_dither_gen`

## Requirements
- R1: After reset the output is low and the counter is at 0.
- R2: A period word of 0, or alignment code 2'b00, disables the channel. The counter is held at 0, the output stays low, and the shadow registers accept new inputs on every clock.
- R3: With dither on, the counter runs from 0 to P[10:1]-1 and wraps to 0. Two such halves form one PWM period of P counts.
- R4: With dither on, the compare value is D[10:1] in the first half. In the second half it is D[10:1]+D[0].
- R5: Alignment code 2'b01 is left aligned. The output is high from the half in which the counter reaches the compare value until the counter wraps. With dither on and a duty that is neither 0% nor 100%, this gives two rising and two falling edges per period.
- R6: A compare value of 0 makes the whole half high. A compare value at or above the half length makes the whole half low.
- R7: With dither off, the counter runs from 0 to P-1, the compare value is D, and there is one rising edge per period.
- R8: Alignment code 2'b10 is right aligned. The output is high while the counter is below the compare value.
- R9: Alignment code 2'b11 is center aligned. The counter counts up from 0 to L-1, holds L-1 for one more tick as it turns, and counts down to 0, so a period is 2L ticks. The up phase is the first half and the down phase is the second. The output is high while the counter is at or above the compare value.
- R10: While the channel runs, new period, duty, dither and alignment inputs take effect only at the end of a full PWM period.
- R11: The counter advances only in cycles where the tick input is high. Otherwise it holds, and the output holds with it.
- R12: The output is registered. It reflects the counter state of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable for the timebase |
| period_i | input | 11 | Period word P |
| duty_i | input | 11 | Duty word D |
| dither_i | input | 1 | Dither enable |
| align_i | input | 2 | 00 off, 01 left, 10 right, 11 center |
| pwm_o | output | 1 | PWM output |

## Verification
The output is due one clock after the counter state it is computed from. A new configuration shows up only after the running period wraps, and then after one more clock. On every rising edge, a reference model in the bench applies those same latencies to its own counter and shadow state, then queues the level the output must show after that edge. A monitor compares that level on the following falling edge. Duty and edge checks over a window are only taken after the bench has waited at least two full periods of the old and the new configuration, so each window covers exactly one settled period.

// File: rtl/pwmd_pkg.sv
package pwmd_pkg;

    typedef enum logic [1:0] {
        ALIGN_OFF    = 2'b00,
        ALIGN_LEFT   = 2'b01,
        ALIGN_RIGHT  = 2'b10,
        ALIGN_CENTER = 2'b11
    } align_e;

endpackage

// File: rtl/pwmd_shadow.sv
module pwmd_shadow
    import pwmd_pkg::*;
#(
    parameter int unsigned W = 11
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] per_i,
    input  logic [W-1:0] duty_i,
    input  logic         dith_i,
    input  align_e       align_i,
    output logic [W-1:0] per_o,
    output logic [W-1:0] duty_o,
    output logic         dith_o,
    output align_e       align_o
);

    typedef struct packed {
        logic [W-1:0] per;
        logic [W-1:0] duty;
        logic         dith;
        align_e       align;
    } shd_t;

    shd_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.per   = per_i;
            s_d.duty  = duty_i;
            s_d.dith  = dith_i;
            s_d.align = align_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{per: '0, duty: '0, dith: 1'b0, align: ALIGN_OFF};
        end else begin
            s_q <= s_d;
        end
    end

    assign per_o   = s_q.per;
    assign duty_o  = s_q.duty;
    assign dith_o  = s_q.dith;
    assign align_o = s_q.align;

    // R10: shadow contents change only in a cycle that was a load cycle
    a_r10_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(s_q));

endmodule

// File: rtl/pwmd_timebase.sv
module pwmd_timebase #(
    parameter int unsigned W = 11
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         en_i,
    input  logic [W-1:0] lim_i,
    input  logic         center_i,
    input  logic         dith_i,
    output logic [W-1:0] cnt_o,
    output logic         half_o,
    output logic         wrap_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         half;
    } tb_t;

    tb_t t_d, t_q;
    logic [W-1:0] lim_m1;
    logic         at_top;
    logic         at_zero;
    logic         end_full;

    assign lim_m1  = lim_i - 1'b1;
    assign at_top  = (t_q.cnt == lim_m1);
    assign at_zero = (t_q.cnt == '0);

    always_comb begin
        if (center_i) begin
            end_full = t_q.half && at_zero;
        end else begin
            end_full = at_top && (!dith_i || t_q.half);
        end
    end

    assign wrap_o = en_i && tick_i && end_full;

    always_comb begin
        t_d = t_q;
        if (!en_i) begin
            t_d.cnt  = '0;
            t_d.half = 1'b0;
        end else if (tick_i) begin
            if (center_i) begin
                if (!t_q.half) begin
                    if (at_top) begin
                        t_d.half = 1'b1;
                    end else begin
                        t_d.cnt = t_q.cnt + 1'b1;
                    end
                end else begin
                    if (at_zero) begin
                        t_d.half = 1'b0;
                    end else begin
                        t_d.cnt = t_q.cnt - 1'b1;
                    end
                end
            end else begin
                if (at_top) begin
                    t_d.cnt  = '0;
                    t_d.half = dith_i ? ~t_q.half : 1'b0;
                end else begin
                    t_d.cnt = t_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            t_q <= '{cnt: '0, half: 1'b0};
        end else begin
            t_q <= t_d;
        end
    end

    assign cnt_o  = t_q.cnt;
    assign half_o = t_q.half;

    // R3: counter stays inside the active range
    a_r3_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |-> (t_q.cnt < lim_i));

    // R3: a dithered edge-aligned wrap switches to the other half
    a_r3_half_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && tick_i && !center_i && dith_i && at_top) |=> (t_q.half != $past(t_q.half)));

    // R11: no tick, no movement
    a_r11_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !tick_i) |=> $stable(t_q));

    // R2: disabled counter sits at zero
    a_r2_held_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (t_q.cnt == '0));

endmodule

// File: rtl/pwmd_compare.sv
module pwmd_compare
    import pwmd_pkg::*;
#(
    parameter int unsigned W = 11
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic [W-1:0] cnt_i,
    input  logic         half_i,
    input  logic [W-1:0] duty_i,
    input  logic         dith_i,
    input  align_e       align_i,
    output logic         pwm_o
);

    typedef struct packed {
        logic pwm;
    } cmp_t;

    cmp_t c_d, c_q;
    logic [W-1:0] base;
    logic [W-1:0] cmp_val;
    logic         inc;
    logic         hit;

    assign base    = dith_i ? {1'b0, duty_i[W-1:1]} : duty_i;
    assign inc     = dith_i && half_i && duty_i[0];
    assign cmp_val = base + {{(W-1){1'b0}}, inc};
    assign hit     = (cnt_i >= cmp_val);

    always_comb begin
        c_d = c_q;
        if (!en_i) begin
            c_d.pwm = 1'b0;
        end else begin
            unique case (align_i)
                ALIGN_LEFT:   c_d.pwm = hit;
                ALIGN_CENTER: c_d.pwm = hit;
                ALIGN_RIGHT:  c_d.pwm = !hit;
                default:      c_d.pwm = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '{pwm: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign pwm_o = c_q.pwm;

    // R2: a disabled channel drives low on the next cycle
    a_r2_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !pwm_o);

    // R6: zero compare in left alignment gives a high output
    a_r6_zero_cmp_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && align_i == ALIGN_LEFT && cmp_val == '0) |=> pwm_o);

    // R8: right alignment is low once the counter reaches the compare value
    a_r8_right_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && align_i == ALIGN_RIGHT && cnt_i >= cmp_val) |=> !pwm_o);

endmodule

// File: rtl/pwm_dither_gen.sv
module pwm_dither_gen
    import pwmd_pkg::*;
#(
    parameter int unsigned W = 11
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic [10:0]  period_i,
    input  logic [10:0]  duty_i,
    input  logic         dither_i,
    input  logic [1:0]   align_i,
    output logic         pwm_o
);

    logic [W-1:0] per_sh;
    logic [W-1:0] duty_sh;
    logic         dith_sh;
    align_e       align_sh;
    logic [W-1:0] lim;
    logic         en;
    logic         load;
    logic         wrap;
    logic [W-1:0] cnt;
    logic         half;

    assign lim  = dith_sh ? {1'b0, per_sh[W-1:1]} : per_sh;
    assign en   = (lim != '0) && (align_sh != ALIGN_OFF);
    assign load = !en || wrap;

    pwmd_shadow #(.W(W)) u_shadow (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load),
        .per_i   (period_i),
        .duty_i  (duty_i),
        .dith_i  (dither_i),
        .align_i (align_e'(align_i)),
        .per_o   (per_sh),
        .duty_o  (duty_sh),
        .dith_o  (dith_sh),
        .align_o (align_sh)
    );

    pwmd_timebase #(.W(W)) u_timebase (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .en_i     (en),
        .lim_i    (lim),
        .center_i (align_sh == ALIGN_CENTER),
        .dith_i   (dith_sh),
        .cnt_o    (cnt),
        .half_o   (half),
        .wrap_o   (wrap)
    );

    pwmd_compare #(.W(W)) u_compare (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en),
        .cnt_i   (cnt),
        .half_i  (half),
        .duty_i  (duty_sh),
        .dith_i  (dith_sh),
        .align_i (align_sh),
        .pwm_o   (pwm_o)
    );

    // R12: a high output always follows a cycle in which the channel was enabled
    a_r12_high_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwm_o |-> $past(en));

    // R10: a running channel reloads only on a full-period wrap
    a_r10_load_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en && load) |-> (tick_i && wrap));

endmodule

// File: tb/pwm_dither_gen_tb_top.sv
module pwm_dither_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic [10:0] period = '0;
    logic [10:0] duty = '0;
    logic        dither = 1'b0;
    logic [1:0]  align = 2'b00;
    logic        pwm;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string phase = "R1";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_dither_gen dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .tick_i   (tick),
        .period_i (period),
        .duty_i   (duty),
        .dither_i (dither),
        .align_i  (align),
        .pwm_o    (pwm)
    );

    // reference model state
    int       m_per = 0, m_duty = 0, m_dith = 0, m_align = 0;
    int       m_cnt = 0, m_half = 0;
    bit       exp_q[$];

    function automatic int m_lim();
        return (m_dith != 0) ? (m_per / 2) : m_per;
    endfunction

    function automatic bit m_en();
        return (m_lim() != 0) && (m_align != 0);
    endfunction

    function automatic bit m_out();
        int c;
        bit h;
        if (!m_en()) return 1'b0;
        if (m_dith != 0) c = (m_duty / 2) + (((m_half != 0) && (m_duty % 2 == 1)) ? 1 : 0);
        else c = m_duty;
        h = (m_cnt >= c);
        if (m_align == 2) return !h;
        return h;
    endfunction

    task automatic m_load();
        m_per = int'(period); m_duty = int'(duty);
        m_dith = int'(dither); m_align = int'(align);
    endtask

    task automatic m_step();
        bit wrap;
        int l;
        l = m_lim();
        wrap = 1'b0;
        if (!m_en()) begin
            m_cnt = 0; m_half = 0; m_load();
        end else if (tick) begin
            if (m_align == 3) begin
                if (m_half == 0) begin
                    if (m_cnt == l - 1) m_half = 1; else m_cnt++;
                end else begin
                    if (m_cnt == 0) begin m_half = 0; wrap = 1'b1; end
                    else m_cnt--;
                end
            end else begin
                if (m_cnt == l - 1) begin
                    wrap = (m_dith == 0) || (m_half == 1);
                    m_cnt = 0;
                    m_half = (m_dith != 0) ? 1 - m_half : 0;
                end else m_cnt++;
            end
            if (wrap) m_load();
        end
    endtask

    // driver side of the scoreboard: expected level after each edge
    always @(posedge clk) begin
        bit e;
        if (!rst_n) begin
            m_per = 0; m_duty = 0; m_dith = 0; m_align = 0; m_cnt = 0; m_half = 0;
            e = 1'b0;
        end else begin
            e = m_out();
            m_step();
        end
        exp_q.push_back(e);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        bit e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(pwm == e, phase, int'(pwm), int'(e));
        end
    end

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            chk(1'b0, "watchdog", cyc, 0);
            report();
            $finish;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int p, input int d, input bit dt, input logic [1:0] al, input string tag);
        @(negedge clk);
        period = 11'(p); duty = 11'(d); dither = dt; align = al; phase = tag;
    endtask

    // count high samples over n samples and rising edges over n transitions
    task automatic window(input int n, input int exp_hi, input int exp_rise, input string tag);
        int hi, rise;
        bit prev;
        hi = 0; rise = 0;
        @(negedge clk);
        prev = pwm;
        for (int i = 0; i < n; i++) begin
            if (pwm) hi++;
            @(negedge clk);
            if (pwm && !prev) rise++;
            prev = pwm;
        end
        chk(hi == exp_hi, {tag, " high count"}, hi, exp_hi);
        chk(rise == exp_rise, {tag, " rising edges"}, rise, exp_rise);
    endtask

    initial begin
        run(4);
        chk(pwm == 1'b0, "R1 reset level", int'(pwm), 0);
        rst_n = 1'b1;
        run(3);
        chk(pwm == 1'b0, "R1 idle after reset", int'(pwm), 0);

        // R2: zero period and off code
        cfg(0, 31, 1'b1, 2'b01, "R2");
        run(5);
        window(50, 0, 0, "R2 zero period");
        cfg(20, 5, 1'b0, 2'b00, "R2");
        run(5);
        window(40, 0, 0, "R2 align off");

        // R4/R5: dithered left, P=200 D=31: 85+84 high, two rises
        cfg(200, 31, 1'b1, 2'b01, "R5");
        run(450);
        window(200, 169, 2, "R4 R5 dither left");

        // R3: D=198 -> compare 99 in both halves, one high count per half
        cfg(200, 198, 1'b1, 2'b01, "R3");
        run(450);
        window(200, 2, 2, "R3 half wrap at 99");

        // R6: compare 0 / compare >= half length
        cfg(200, 1, 1'b1, 2'b01, "R6");
        run(450);
        window(200, 199, 1, "R6 zero compare");
        cfg(200, 201, 1'b1, 2'b01, "R6");
        run(450);
        window(200, 0, 0, "R6 compare at limit");
        cfg(200, 199, 1'b1, 2'b01, "R6");
        run(450);
        window(200, 1, 1, "R6 second half beyond limit");

        // R7: no dither
        cfg(20, 5, 1'b0, 2'b01, "R7");
        run(450);
        window(20, 15, 1, "R7 plain left");

        // R10: duty change mid-period, scoreboard checks every cycle
        run(7);
        cfg(20, 12, 1'b0, 2'b01, "R10");
        run(60);
        window(20, 8, 1, "R10 new duty applied");

        // R8: right aligned
        cfg(20, 5, 1'b0, 2'b10, "R8");
        run(60);
        window(20, 5, 1, "R8 right");

        // R9: center aligned, plain and dithered
        cfg(20, 5, 1'b0, 2'b11, "R9");
        run(100);
        window(40, 30, 1, "R9 center");
        cfg(20, 7, 1'b1, 2'b11, "R9");
        run(100);
        window(20, 13, 1, "R9 center dither");

        // R11: tick every other cycle doubles the period in clocks
        cfg(20, 5, 1'b0, 2'b01, "R11");
        run(60);
        fork
            begin
                for (int i = 0; i < 200; i++) begin
                    @(negedge clk);
                    tick = ~tick;
                end
            end
            begin
                run(80);
                window(40, 30, 1, "R11 half-rate tick");
            end
        join
        tick = 1'b1;

        // R12 / R2: back to disabled, output low one cycle after
        cfg(0, 5, 1'b0, 2'b01, "R12");
        run(60);
        chk(pwm == 1'b0, "R12 disabled again", int'(pwm), 0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule